// File: doc/BRIEF.md
# External Interrupt Sense Controller

The block conditions eight maskable external interrupt pins and one non-maskable pin before they reach a parent interrupt controller. Every pin first passes through a two-flop synchronizer. Each maskable line then has its own 2-bit sense code, which selects one of four modes: low level, falling edge, rising edge or both edges. Edge events are latched into pending flags. Software reads these flags through a 16-bit register interface and clears them by writing zero.

The non-maskable channel has a single edge select (falling or rising), its own pending flag and a read-only view of the synchronized pin level. One request output per maskable line, plus one for the non-maskable channel, drives the parent controller. Priority and masking belong to that parent.

The register interface uses a byte address. Bit 0 of the address is ignored, so each register occupies one 16-bit word. Writes take effect at the clock edge where `reg_we_i` is high. Reads are combinational from `reg_addr_i`.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset all sense fields are 0, every pending flag is 0, the non-maskable edge select is 0 (falling), and the non-maskable flag is 0. With all pins held high this means: word 0 reads 16'h8000, word 1 reads 0, word 2 reads 0, and all request outputs are 0.
- R2: Each pin passes a two-flop synchronizer. A pin change becomes visible in word 0 bit 15 two clock edges after it is driven, and not after one.
- R3: Word 1 (byte offset 2) holds the sense field of line n at bits [2n+1:2n]. It is fully readable and writable. The codes are: 0 = low level, 1 = falling edge, 2 = rising edge, 3 = both edges.
- R4: In code 1 a falling edge on a line sets its pending flag, and a rising edge does not.
- R5: In code 2 a rising edge sets the pending flag, and a falling edge does not.
- R6: In code 3 both a rising and a falling edge set the pending flag.
- R7: In code 0 the request output of a line is high exactly while the synchronized pin is low. The pending flag is held set while the pin is low, so a write-zero clear has no lasting effect. After the pin rises the output drops, and the flag can then be cleared.
- R8: Word 2 (byte offset 4) holds the pending flag of line n at bit n, and bits 15:8 read 0. Writing 0 to a bit clears that flag. Writing 1 to a bit leaves that flag unchanged.
- R9: If an edge sets a flag in the same cycle as a write-zero clear of that flag, the flag ends up set.
- R10: Word 0 (byte offset 0) bit 8 selects the non-maskable edge: 0 = falling, 1 = rising. Bit 1 is the non-maskable flag. It sets only on the selected edge, writing 0 to it clears it, and `nmi_req_o` equals it.
- R11: Word 0 bit 15 reads the synchronized non-maskable pin level, and writes do not change it. Other bits of word 0 read 0, and word 3 reads 0.
- R12: In an edge code, the request output of a line equals its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 8 | Maskable external interrupt pins |
| nmi_pin_i | input | 1 | Non-maskable external interrupt pin |
| reg_addr_i | input | 3 | Byte address of the register word |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| irq_req_o | output | 8 | Request toward the parent controller, one per line |
| nmi_req_o | output | 1 | Non-maskable request toward the parent |

## Verification
The assertions assume the following:
- Pins change at most once per clock and are otherwise stable.
- Pins are idle high across reset. The synchronizer and the edge-history flops reset to 1, so a pin held high through reset produces no edge.
- The write strobe is driven from register-clean signals, so any clear is seen in exactly one cycle.

The stimulus changes every pin and bus signal only on the falling clock edge, holds pins high through reset, and reconfigures a line's sense code only while its pin is high. The coincident edge-and-clear case is placed so that the clearing write strobe lands on the same edge at which the detector latches the event.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned ADDR_W    = 3;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  // word index = byte address [2:1]
  localparam logic [1:0] WORD_CTRL0 = 2'd0;
  localparam logic [1:0] WORD_CTRL1 = 2'd1;
  localparam logic [1:0] WORD_PEND  = 2'd2;

  localparam int unsigned NMI_LVL_BIT  = 15;
  localparam int unsigned NMI_ESEL_BIT = 8;
  localparam int unsigned NMI_FLAG_BIT = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // idle-high reset: a pin held high through reset yields no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_line_det.sv
module irq_line_det
  import irq_sense_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  sense_e     mode_i,
  input  logic       clr_i,
  output logic       pend_o,
  output logic       req_o
);
  logic prev_q, pend_q;
  logic rise_c, fall_c, set_c;

  assign rise_c = lvl_i & ~prev_q;
  assign fall_c = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  set_c = ~lvl_i;
      SENSE_FALL: set_c = fall_c;
      SENSE_RISE: set_c = rise_c;
      default:    set_c = rise_c | fall_c;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // set beats clear so a coincident event is kept
      pend_q <= set_c | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;
  assign req_o  = (mode_i == SENSE_LOW) ? ~lvl_i : pend_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_c |=> pend_q);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);

  // R4
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(set_c));
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
#(
  parameter int unsigned N = NUM_LINES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      irq_pin_i,
  input  logic              nmi_pin_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [N-1:0]      irq_req_o,
  output logic              nmi_req_o
);
  logic [N-1:0]       irq_lvl, irq_pend, irq_clr;
  logic               nmi_lvl, nmi_pend, nmi_clr, nmi_esel_q;
  logic [2*N-1:0]     sense_q;
  logic [1:0]         word;
  logic               wr_ctrl0, wr_ctrl1, wr_pend;
  sense_e             nmi_mode;

  assign word     = reg_addr_i[2:1];
  assign wr_ctrl0 = reg_we_i && (word == WORD_CTRL0);
  assign wr_ctrl1 = reg_we_i && (word == WORD_CTRL1);
  assign wr_pend  = reg_we_i && (word == WORD_PEND);

  irq_sync #(.WIDTH(N + 1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({nmi_pin_i, irq_pin_i}),
    .q_o    ({nmi_lvl, irq_lvl})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q    <= '0;
      nmi_esel_q <= 1'b0;
    end else begin
      if (wr_ctrl1) sense_q <= reg_wdata_i[2*N-1:0];
      if (wr_ctrl0) nmi_esel_q <= reg_wdata_i[NMI_ESEL_BIT];
    end
  end

  for (genvar n = 0; n < N; n++) begin : g_line
    assign irq_clr[n] = wr_pend & ~reg_wdata_i[n];
    irq_line_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (irq_lvl[n]),
      .mode_i (sense_e'(sense_q[2*n +: 2])),
      .clr_i  (irq_clr[n]),
      .pend_o (irq_pend[n]),
      .req_o  (irq_req_o[n])
    );
  end

  // esel 0 -> falling code, 1 -> rising code
  assign nmi_mode = nmi_esel_q ? SENSE_RISE : SENSE_FALL;
  assign nmi_clr  = wr_ctrl0 & ~reg_wdata_i[NMI_FLAG_BIT];

  irq_line_det u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (nmi_lvl),
    .mode_i (nmi_mode),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend),
    .req_o  (nmi_req_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (word)
      WORD_CTRL0: begin
        reg_rdata_o[NMI_LVL_BIT]  = nmi_lvl;
        reg_rdata_o[NMI_ESEL_BIT] = nmi_esel_q;
        reg_rdata_o[NMI_FLAG_BIT] = nmi_pend;
      end
      WORD_CTRL1: reg_rdata_o[2*N-1:0] = sense_q;
      WORD_PEND:  reg_rdata_o[N-1:0]   = irq_pend;
      default:    reg_rdata_o = '0;
    endcase
  end

  // R10
  nmi_edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_req_o) |-> $past(nmi_esel_q ? (nmi_lvl & ~$past(nmi_lvl))
                                          : (~nmi_lvl & $past(nmi_lvl))));

  // R3
  sense_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl1 |=> $stable(sense_q));
endmodule

// File: tb/irq_sense_ctrl_tb.sv
module irq_sense_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin = 8'hFF;
  logic        nmi_pin = 1'b1;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  irq_req;
  logic        nmi_req;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  irq_sense_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(irq_pin), .nmi_pin_i(nmi_pin),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_req_o(irq_req), .nmi_req_o(nmi_req)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd0, d); chk("R1 ctrl0", d, 16'h8000);
    rd(3'd2, d); chk("R1 ctrl1", d, 16'h0000);
    rd(3'd4, d); chk("R1 pend", d, 16'h0000);
    chk("R1 req", {7'd0, nmi_req, irq_req}, 16'h0);
  endtask

  task automatic t_sense_reg();
    logic [15:0] d;
    // line0 fall, line1 rise, line2 both, line3 low, others rise
    wr(3'd2, 16'b10_10_10_10_00_11_10_01);
    rd(3'd2, d); chk("R3 ctrl1 readback", d, 16'hAA39);
  endtask

  task automatic t_fall();
    logic [15:0] d;
    @(negedge clk); irq_pin[0] = 1'b0; idle(4);
    rd(3'd4, d); chk("R4 fall sets", d, 16'h0001);
    chk("R12 req follows flag", {8'd0, irq_req}, 16'h0001);
    wr(3'd4, 16'hFFFE); idle(1);
    irq_pin[0] = 1'b1; idle(4);
    rd(3'd4, d); chk("R4 rise ignored", d, 16'h0000);
  endtask

  task automatic t_rise();
    logic [15:0] d;
    @(negedge clk); irq_pin[1] = 1'b0; idle(4);
    rd(3'd4, d); chk("R5 fall ignored", d, 16'h0000);
    irq_pin[1] = 1'b1; idle(4);
    rd(3'd4, d); chk("R5 rise sets", d, 16'h0002);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_both();
    logic [15:0] d;
    @(negedge clk); irq_pin[2] = 1'b0; idle(4);
    rd(3'd4, d); chk("R6 fall sets", d, 16'h0004);
    wr(3'd4, 16'hFFFB); idle(1);
    rd(3'd4, d); chk("R8 write0 clears", d, 16'h0000);
    irq_pin[2] = 1'b1; idle(4);
    rd(3'd4, d); chk("R6 rise sets", d, 16'h0004);
  endtask

  task automatic t_write_one();
    logic [15:0] d;
    // line2 pending from t_both; set line0 too
    @(negedge clk); irq_pin[0] = 1'b0; idle(4);
    wr(3'd4, 16'hFFFB); idle(1);
    rd(3'd4, d); chk("R8 write1 keeps", d, 16'h0001);
    irq_pin[0] = 1'b1;
    wr(3'd4, 16'h0000); idle(4);
    rd(3'd4, d); chk("R8 all cleared", d, 16'h0000);
  endtask

  task automatic t_level();
    logic [15:0] d;
    @(negedge clk); irq_pin[3] = 1'b0; idle(1);
    chk("R7 not yet", {8'd0, irq_req}, 16'h0000);
    idle(3);
    chk("R7 low req", {8'd0, irq_req}, 16'h0008);
    wr(3'd4, 16'h0000); idle(2);
    rd(3'd4, d); chk("R7 clear no effect", d, 16'h0008);
    irq_pin[3] = 1'b1; idle(4);
    chk("R7 req drops", {8'd0, irq_req}, 16'h0000);
    wr(3'd4, 16'h0000); idle(1);
    rd(3'd4, d); chk("R7 flag cleared", d, 16'h0000);
  endtask

  task automatic t_coincide();
    logic [15:0] d;
    @(negedge clk); irq_pin[0] = 1'b0;
    @(negedge clk);
    wr(3'd4, 16'h0000);
    rd(3'd4, d); chk("R9 edge beats clear", d, 16'h0001);
    irq_pin[0] = 1'b1;
    wr(3'd4, 16'h0000); idle(4);
  endtask

  task automatic t_nmi();
    logic [15:0] d;
    @(negedge clk); nmi_pin = 1'b0;
    @(negedge clk); rd(3'd0, d); chk("R2 one edge old", d & 16'h8000, 16'h8000);
    @(negedge clk); rd(3'd0, d); chk("R11 level low", d & 16'h8000, 16'h0000);
    idle(2);
    rd(3'd0, d); chk("R10 falling flag", d, 16'h0002);
    chk("R10 nmi_req", {15'd0, nmi_req}, 16'h1);
    wr(3'd0, 16'h0100); idle(1);
    rd(3'd0, d); chk("R10 clear and esel", d, 16'h0100);
    nmi_pin = 1'b1; idle(4);
    rd(3'd0, d); chk("R10 rising flag", d, 16'h8102);
    wr(3'd0, 16'h8100); idle(1);
    rd(3'd0, d); chk("R11 bit15 not writable clear", d, 16'h8100);
    nmi_pin = 1'b0; idle(4);
    rd(3'd0, d); chk("R10 fall ignored", d, 16'h0100);
    rd(3'd6, d); chk("R11 word3 zero", d, 16'h0000);
    nmi_pin = 1'b1; idle(4);
    wr(3'd0, 16'h0000);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1'b1; idle(2);
        t_reset();
        t_sense_reg();
        t_fall();
        t_rise();
        t_both();
        t_write_one();
        t_level();
        t_coincide();
        t_nmi();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule